// File: doc/BRIEF.md
# Page Pointer List Walker

The walker turns one transfer description into the ordered list of contiguous memory pieces that a DMA engine must visit. A transfer is described by a byte length and two 64-bit pointers. The first pointer may start anywhere inside a page. The second pointer is either the address of a single further page or the address of a list of 8-byte page addresses. Which of the two it is depends on how many bytes are left after the first piece. The page size is a power of two chosen at each start.

Each piece leaves the block as an (address, length) pair under a valid/ready handshake. List pages are fetched through a request/response read port. A request carries a start address and a count of 8-byte words. The responses come back in order, one word per beat. When a list runs out and more than one page is still to be described, its last slot holds the address of the next list page, and the walker follows it.

Every pointer taken from memory is checked. On a bad pointer the walker stops producing pieces and reports an invalid-field error with the do-not-retry indication set.

Top module: `page_walker`

## Requirements
- R1: On `start` the walker latches all inputs. If `ptrA` is zero it reports an error and emits no segment. Otherwise the first segment has address `ptrA` and length min(`xferLen`, page − (`ptrA` mod page)).
- R2: When the first segment covers the whole transfer, `doneFlag` rises after it and no read request is issued.
- R3: When bytes remain after the first segment and `ptrB` is zero, the walker reports an error after emitting the first segment.
- R4: When the remaining length is at most one page, `ptrB` is a direct page address. If `ptrB` is not page aligned the walker reports an error. Otherwise it emits one segment with address `ptrB` and the remaining length, and issues no read request.
- R5: When the remaining length exceeds one page, the walker issues one read request with `rdReqAddr` = `ptrB` and `rdReqCount` = min(page/8, ceil(remaining/page)). Each response beat is one list entry whose 64-bit value is `rdRspData` as delivered, with the byte at the lowest address in bits 7:0.
- R6: A data entry that is zero or not page aligned causes an error. Otherwise it yields a segment with the entry as address and length min(remaining, page).
- R7: The entry in slot page/8 − 1 of a list, taken while more than one page remains, is a chain pointer. It must be nonzero and page aligned, or an error results. If it is valid, a new request is issued at it, with its count computed as in R5 from the remaining length.
- R8: While `segValid` is high and `segReady` is low, `segAddr` and `segLen` hold still. No segment crosses a page boundary.
- R9: An error sets `errFlag`=1, `errCode`=8'h02 and `noRetry`=1. These hold until the next `start`, and no segment follows. Response beats still owed by the current request are accepted before `errFlag` rises.
- R10: `doneFlag` holds until the next accepted `start`. A `start` while `busy` is high is ignored.
- R11: The page size is 2^`pageBits`, sampled at `start`, with `pageBits` between `PG_MIN` and `PG_MAX` (defaults 4 and 16).

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rstN | input | 1 | Active-low synchronous reset |
| start | input | 1 | Begin a walk; ignored while busy |
| xferLen | input | LEN_W | Transfer length in bytes |
| ptrA | input | 64 | First page pointer |
| ptrB | input | 64 | Second page pointer or list address |
| pageBits | input | PGB_W | log2 of the page size |
| busy | output | 1 | A walk is in progress |
| segValid | output | 1 | Segment available |
| segReady | input | 1 | Segment accepted |
| segAddr | output | 64 | Segment start address |
| segLen | output | LEN_W | Segment length in bytes |
| rdReqValid | output | 1 | List read request valid |
| rdReqReady | input | 1 | List read request accepted |
| rdReqAddr | output | 64 | Address of first list word |
| rdReqCount | output | CNT_W | Number of 8-byte words requested |
| rdRspValid | input | 1 | Response beat valid |
| rdRspReady | output | 1 | Response beat accepted |
| rdRspData | input | 64 | One list entry |
| doneFlag | output | 1 | Walk finished cleanly |
| errFlag | output | 1 | Walk ended in error |
| errCode | output | 8 | Status code, 8'h02 on error, else 0 |
| noRetry | output | 1 | Do-not-retry indication on error |

## Verification
A wrong remaining-length register shows at the ports within one segment: the next piece is cut to the wrong length, or the walk ends a piece early or late. A wrong slot index is seen at the end of a full list page. The chain pointer comes out as a data segment, or a data entry is taken as the next list address and shows up as an unexpected read request. A wrong beat count leaves owed response beats unaccepted, or accepts beats that were never requested. The bench compares every segment and every request in order against its own model of the walk. It also checks that the response queue is empty when a flag rises.

// File: rtl/page_walker_pkg.sv
package page_walker_pkg;

  localparam int ADDR_W = 64;
  localparam logic [7:0] ERR_INVALID_FIELD = 8'h02;

  typedef enum logic [3:0] {
    S_IDLE, S_FIRST, S_EMIT1, S_SECOND, S_EMIT2,
    S_REQ, S_BEAT, S_EMIT3, S_DRAIN, S_DONE, S_ERR
  } walkState_e;

  // strobes from control to datapath
  typedef struct packed {
    logic loadCmd;
    logic setFirst;
    logic setDirect;
    logic listFromB;
    logic listFromEntry;
    logic takeBeat;
    logic setEntry;
    logic segSent;
  } dpCtl_t;

  // conditions from datapath to control
  typedef struct packed {
    logic ptrAZero;
    logic ptrBZero;
    logic ptrBMisaligned;
    logic remFitsPage;
    logic lastSeg;
    logic chainSlot;
    logic entryBad;
    logic lastBeat;
  } dpStat_t;

endpackage

// File: rtl/page_walker_dp.sv
module page_walker_dp
  import page_walker_pkg::*;
#(
  parameter int LEN_W = 32,
  parameter int PGB_W = 5,
  parameter int CNT_W = 14
) (
  input  logic              clk,
  input  logic              rstN,
  input  dpCtl_t            ctl,
  input  logic [LEN_W-1:0]  xferLen,
  input  logic [ADDR_W-1:0] ptrA,
  input  logic [ADDR_W-1:0] ptrB,
  input  logic [PGB_W-1:0]  pageBits,
  input  logic [ADDR_W-1:0] rdRspData,
  input  logic              segValidIn,
  input  logic              rdReqValidIn,
  input  logic              rdRspReadyIn,
  output dpStat_t           stat,
  output logic [ADDR_W-1:0] segAddr,
  output logic [LEN_W-1:0]  segLen,
  output logic [ADDR_W-1:0] rdReqAddr,
  output logic [CNT_W-1:0]  rdReqCount
);

  localparam int PAD_W = ADDR_W - LEN_W;
  localparam int NEED_W = LEN_W + 1;

  logic [ADDR_W-1:0] ptrAR, ptrBR, segAddrR, reqAddrR;
  logic [LEN_W-1:0]  remLen, segLenR;
  logic [PGB_W-1:0]  pgBitsR;
  logic [CNT_W-1:0]  reqCountR, beatsLeft, slotIdx;

  logic [ADDR_W-1:0] pgSize, pgMask, remWide, firstRoom;
  logic [LEN_W-1:0]  firstLen, pageLen;
  logic [NEED_W-1:0] pagesNeeded;
  logic [CNT_W-1:0]  eppCnt, burstCnt;
  logic              remFitsPage;

  assign pgSize      = ADDR_W'(1) << pgBitsR;
  assign pgMask      = pgSize - 1'b1;
  assign remWide     = {{PAD_W{1'b0}}, remLen};
  assign remFitsPage = remWide <= pgSize;
  assign firstRoom   = pgSize - (ptrAR & pgMask);
  assign firstLen    = (remWide < firstRoom) ? remLen : firstRoom[LEN_W-1:0];
  assign pageLen     = remFitsPage ? remLen : pgSize[LEN_W-1:0];
  assign pagesNeeded = ({1'b0, remLen} + pgMask[NEED_W-1:0]) >> pgBitsR;
  assign eppCnt      = CNT_W'(pgSize >> 3);
  assign burstCnt    = (pagesNeeded < {{(NEED_W-CNT_W){1'b0}}, eppCnt})
                       ? pagesNeeded[CNT_W-1:0] : eppCnt;

  assign stat.ptrAZero       = (ptrAR == '0);
  assign stat.ptrBZero       = (ptrBR == '0);
  assign stat.ptrBMisaligned = |(ptrBR & pgMask);
  assign stat.remFitsPage    = remFitsPage;
  assign stat.lastSeg        = (remLen == segLenR);
  assign stat.chainSlot      = (slotIdx == eppCnt - 1'b1) && !remFitsPage;
  assign stat.entryBad       = (rdRspData == '0) || |(rdRspData & pgMask);
  assign stat.lastBeat       = (beatsLeft == CNT_W'(1));

  always_ff @(posedge clk) begin
    if (!rstN) begin
      ptrAR     <= '0;
      ptrBR     <= '0;
      remLen    <= '0;
      pgBitsR   <= '0;
      segAddrR  <= '0;
      segLenR   <= '0;
      reqAddrR  <= '0;
      reqCountR <= '0;
      beatsLeft <= '0;
      slotIdx   <= '0;
    end else begin
      if (ctl.loadCmd) begin
        ptrAR   <= ptrA;
        ptrBR   <= ptrB;
        remLen  <= xferLen;
        pgBitsR <= pageBits;
      end else if (ctl.segSent) begin
        remLen <= remLen - segLenR;
      end

      if (ctl.setFirst) begin
        segAddrR <= ptrAR;
        segLenR  <= firstLen;
      end else if (ctl.setDirect) begin
        segAddrR <= ptrBR;
        segLenR  <= remLen;
      end else if (ctl.setEntry) begin
        segAddrR <= rdRspData;
        segLenR  <= pageLen;
      end

      if (ctl.listFromB || ctl.listFromEntry) begin
        reqAddrR  <= ctl.listFromB ? ptrBR : rdRspData;
        reqCountR <= burstCnt;
        beatsLeft <= burstCnt;
        slotIdx   <= '0;
      end else if (ctl.takeBeat) begin
        beatsLeft <= beatsLeft - 1'b1;
        slotIdx   <= slotIdx + 1'b1;
      end
    end
  end

  assign segAddr    = segAddrR;
  assign segLen     = segLenR;
  assign rdReqAddr  = reqAddrR;
  assign rdReqCount = reqCountR;

  // R8: a shown segment stays inside one page
  p_seg_in_page_r8: assert property (@(posedge clk) disable iff (!rstN)
    segValidIn |-> ({{PAD_W{1'b0}}, segLenR} <= pgSize - (segAddrR & pgMask)));

  // R6: a shown segment never exceeds what is left of the transfer
  p_seg_fits_rem_r6: assert property (@(posedge clk) disable iff (!rstN)
    segValidIn |-> (segLenR <= remLen));

  // R5: a request asks for at least one entry and at most a page of them
  p_req_count_r5: assert property (@(posedge clk) disable iff (!rstN)
    rdReqValidIn |-> (reqCountR != '0) && (reqCountR <= eppCnt));

  // R9: beats are only taken while some are owed
  p_rsp_owed_r9: assert property (@(posedge clk) disable iff (!rstN)
    rdRspReadyIn |-> (beatsLeft != '0));

endmodule

// File: rtl/page_walker_ctrl.sv
module page_walker_ctrl
  import page_walker_pkg::*;
(
  input  logic    clk,
  input  logic    rstN,
  input  logic    start,
  input  logic    segReady,
  input  logic    rdReqReady,
  input  logic    rdRspValid,
  input  dpStat_t stat,
  output dpCtl_t  ctl,
  output logic    busy,
  output logic    segValid,
  output logic    rdReqValid,
  output logic    rdRspReady,
  output logic    doneFlag,
  output logic    errFlag
);

  walkState_e state, nextState;

  always_ff @(posedge clk) begin
    if (!rstN) state <= S_IDLE;
    else       state <= nextState;
  end

  always_comb begin
    nextState = state;
    ctl       = '0;
    unique case (state)
      S_IDLE, S_DONE, S_ERR: begin
        if (start) begin
          ctl.loadCmd = 1'b1;
          nextState   = S_FIRST;
        end
      end
      S_FIRST: begin
        if (stat.ptrAZero) begin
          nextState = S_ERR;
        end else begin
          ctl.setFirst = 1'b1;
          nextState    = S_EMIT1;
        end
      end
      S_EMIT1: begin
        if (segReady) begin
          ctl.segSent = 1'b1;
          nextState   = stat.lastSeg ? S_DONE : S_SECOND;
        end
      end
      S_SECOND: begin
        if (stat.ptrBZero) begin
          nextState = S_ERR;
        end else if (stat.remFitsPage) begin
          if (stat.ptrBMisaligned) begin
            nextState = S_ERR;
          end else begin
            ctl.setDirect = 1'b1;
            nextState     = S_EMIT2;
          end
        end else begin
          ctl.listFromB = 1'b1;
          nextState     = S_REQ;
        end
      end
      S_EMIT2: begin
        if (segReady) begin
          ctl.segSent = 1'b1;
          nextState   = S_DONE;
        end
      end
      S_REQ: begin
        if (rdReqReady) nextState = S_BEAT;
      end
      S_BEAT: begin
        if (rdRspValid) begin
          ctl.takeBeat = 1'b1;
          if (stat.chainSlot) begin
            if (stat.entryBad) begin
              nextState = S_ERR;
            end else begin
              ctl.listFromEntry = 1'b1;
              nextState         = S_REQ;
            end
          end else if (stat.entryBad) begin
            nextState = stat.lastBeat ? S_ERR : S_DRAIN;
          end else begin
            ctl.setEntry = 1'b1;
            nextState    = S_EMIT3;
          end
        end
      end
      S_EMIT3: begin
        if (segReady) begin
          ctl.segSent = 1'b1;
          nextState   = stat.lastSeg ? S_DONE : S_BEAT;
        end
      end
      S_DRAIN: begin
        if (rdRspValid) begin
          ctl.takeBeat = 1'b1;
          if (stat.lastBeat) nextState = S_ERR;
        end
      end
      default: nextState = S_IDLE;
    endcase
  end

  assign busy       = !(state inside {S_IDLE, S_DONE, S_ERR});
  assign segValid   = state inside {S_EMIT1, S_EMIT2, S_EMIT3};
  assign rdReqValid = (state == S_REQ);
  assign rdRspReady = state inside {S_BEAT, S_DRAIN};
  assign doneFlag   = (state == S_DONE);
  assign errFlag    = (state == S_ERR);

endmodule

// File: rtl/page_walker.sv
module page_walker
  import page_walker_pkg::*;
#(
  parameter int LEN_W  = 32,
  parameter int PG_MIN = 4,
  parameter int PG_MAX = 16,
  localparam int PGB_W = $clog2(PG_MAX + 1),
  localparam int CNT_W = PG_MAX - 2
) (
  input  logic              clk,
  input  logic              rstN,
  input  logic              start,
  input  logic [LEN_W-1:0]  xferLen,
  input  logic [63:0]       ptrA,
  input  logic [63:0]       ptrB,
  input  logic [PGB_W-1:0]  pageBits,
  output logic              busy,
  output logic              segValid,
  input  logic              segReady,
  output logic [63:0]       segAddr,
  output logic [LEN_W-1:0]  segLen,
  output logic              rdReqValid,
  input  logic              rdReqReady,
  output logic [63:0]       rdReqAddr,
  output logic [CNT_W-1:0]  rdReqCount,
  input  logic              rdRspValid,
  output logic              rdRspReady,
  input  logic [63:0]       rdRspData,
  output logic              doneFlag,
  output logic              errFlag,
  output logic [7:0]        errCode,
  output logic              noRetry
);

  dpCtl_t  ctl;
  dpStat_t stat;

  page_walker_ctrl u_ctrl (
    .clk        (clk),
    .rstN       (rstN),
    .start      (start),
    .segReady   (segReady),
    .rdReqReady (rdReqReady),
    .rdRspValid (rdRspValid),
    .stat       (stat),
    .ctl        (ctl),
    .busy       (busy),
    .segValid   (segValid),
    .rdReqValid (rdReqValid),
    .rdRspReady (rdRspReady),
    .doneFlag   (doneFlag),
    .errFlag    (errFlag)
  );

  page_walker_dp #(
    .LEN_W (LEN_W),
    .PGB_W (PGB_W),
    .CNT_W (CNT_W)
  ) u_dp (
    .clk          (clk),
    .rstN         (rstN),
    .ctl          (ctl),
    .xferLen      (xferLen),
    .ptrA         (ptrA),
    .ptrB         (ptrB),
    .pageBits     (pageBits),
    .rdRspData    (rdRspData),
    .segValidIn   (segValid),
    .rdReqValidIn (rdReqValid),
    .rdRspReadyIn (rdRspReady),
    .stat         (stat),
    .segAddr      (segAddr),
    .segLen       (segLen),
    .rdReqAddr    (rdReqAddr),
    .rdReqCount   (rdReqCount)
  );

  assign errCode = errFlag ? ERR_INVALID_FIELD : 8'h00;
  assign noRetry = errFlag;

  // R8: an offered segment is held until taken
  p_seg_hold_r8: assert property (@(posedge clk) disable iff (!rstN)
    segValid && !segReady |=> segValid && $stable(segAddr) && $stable(segLen));

  // R5: an offered read request is held until taken
  p_req_hold_r5: assert property (@(posedge clk) disable iff (!rstN)
    rdReqValid && !rdReqReady |=> rdReqValid && $stable(rdReqAddr) && $stable(rdReqCount));

  // R11: a walk is only started with a supported page size
  p_page_range_r11: assert property (@(posedge clk) disable iff (!rstN)
    start && !busy |-> (pageBits >= PGB_W'(PG_MIN)) && (pageBits <= PGB_W'(PG_MAX)));

endmodule

// File: tb/page_walker_bench.sv
module page_walker_bench;

  localparam int PERIOD = 10;
  localparam int LEN_W  = 32;
  localparam int PG_MIN = 4;
  localparam int PG_MAX = 16;
  localparam int PGB_W  = $clog2(PG_MAX + 1);
  localparam int CNT_W  = PG_MAX - 2;
  localparam logic [63:0] LIST0 = 64'h0000_0020_0000_0000;

  logic clk = 1'b0;
  logic rstN = 1'b0;
  logic start = 1'b0;
  logic [LEN_W-1:0] xferLen = '0;
  logic [63:0] ptrA = '0, ptrB = '0;
  logic [PGB_W-1:0] pageBits = PGB_W'(PG_MIN);
  logic busy, segValid, segReady = 1'b0;
  logic [63:0] segAddr;
  logic [LEN_W-1:0] segLen;
  logic rdReqValid, rdReqReady = 1'b0;
  logic [63:0] rdReqAddr;
  logic [CNT_W-1:0] rdReqCount;
  logic rdRspValid = 1'b0, rdRspReady;
  logic [63:0] rdRspData = '0;
  logic doneFlag, errFlag, noRetry;
  logic [7:0] errCode;

  always #(PERIOD / 2) clk = ~clk;

  page_walker #(.LEN_W(LEN_W), .PG_MIN(PG_MIN), .PG_MAX(PG_MAX)) u_page_walker (
    .clk(clk), .rstN(rstN), .start(start), .xferLen(xferLen), .ptrA(ptrA), .ptrB(ptrB),
    .pageBits(pageBits), .busy(busy), .segValid(segValid), .segReady(segReady),
    .segAddr(segAddr), .segLen(segLen), .rdReqValid(rdReqValid), .rdReqReady(rdReqReady),
    .rdReqAddr(rdReqAddr), .rdReqCount(rdReqCount), .rdRspValid(rdRspValid),
    .rdRspReady(rdRspReady), .rdRspData(rdRspData), .doneFlag(doneFlag), .errFlag(errFlag),
    .errCode(errCode), .noRetry(noRetry)
  );

  int checks = 0;
  int errors = 0;

  logic [63:0] mem [logic [63:0]];
  logic [63:0] eSegAddr[$];
  logic [63:0] eSegLen[$];
  string       eSegTag[$];
  logic [63:0] eReqAddr[$];
  logic [63:0] eReqCnt[$];
  string       eReqTag[$];
  bit          eErr;
  logic [63:0] pending[$];
  logic [63:0] listCursor;

  task automatic chk(bit ok, string tag, string what, logic [63:0] act, logic [63:0] exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s %s actual=%h expected=%h", tag, what, act, exp);
    end
  endtask

  function automatic logic [63:0] rdMem(logic [63:0] a);
    return mem.exists(a) ? mem[a] : 64'h0;
  endfunction

  function automatic logic [63:0] min64(logic [63:0] a, logic [63:0] b);
    return (a < b) ? a : b;
  endfunction

  function automatic bit badPtr(logic [63:0] v, logic [63:0] mask);
    return (v == 64'h0) || ((v & mask) != 64'h0);
  endfunction

  // reference walk from the requirements
  task automatic buildExpect(logic [63:0] len, logic [63:0] pa, logic [63:0] pb, int pbits);
    logic [63:0] pg, mask, rem, room, first, list, epp, need, cnt, e, sl;
    string sTag, rTag;
    eSegAddr.delete(); eSegLen.delete(); eSegTag.delete();
    eReqAddr.delete(); eReqCnt.delete(); eReqTag.delete();
    eErr = 1'b0;
    pg = 64'h1 << pbits;
    mask = pg - 1;
    rem = len;
    if (pa == 0) begin eErr = 1'b1; return; end
    room = pg - (pa & mask);
    first = min64(rem, room);
    eSegAddr.push_back(pa); eSegLen.push_back(first); eSegTag.push_back("R1");
    rem -= first;
    if (rem == 0) return;
    if (pb == 0) begin eErr = 1'b1; return; end
    if (rem <= pg) begin
      if ((pb & mask) != 0) begin eErr = 1'b1; return; end
      eSegAddr.push_back(pb); eSegLen.push_back(rem); eSegTag.push_back("R4");
      return;
    end
    list = pb;
    epp = pg >> 3;
    sTag = "R6";
    rTag = "R5";
    while (1) begin
      bit chained;
      chained = 1'b0;
      need = (rem + pg - 1) / pg;
      cnt = min64(epp, need);
      eReqAddr.push_back(list); eReqCnt.push_back(cnt); eReqTag.push_back(rTag);
      for (logic [63:0] i = 0; i < cnt; i++) begin
        e = rdMem(list + 8 * i);
        if (i == epp - 1 && rem > pg) begin
          if (badPtr(e, mask)) begin eErr = 1'b1; return; end
          list = e;
          chained = 1'b1;
          break;
        end
        if (badPtr(e, mask)) begin eErr = 1'b1; return; end
        sl = min64(rem, pg);
        eSegAddr.push_back(e); eSegLen.push_back(sl); eSegTag.push_back(sTag);
        rem -= sl;
        if (rem == 0) return;
      end
      if (!chained) return;
      sTag = "R7";
      rTag = "R7";
    end
  endtask

  // lays out nLists chained list pages starting at base
  task automatic fillLists(logic [63:0] base, int pbits, int nLists);
    logic [63:0] pg, epp, cur, nxt;
    pg = 64'h1 << pbits;
    epp = pg >> 3;
    cur = base;
    for (int k = 0; k < nLists; k++) begin
      nxt = listCursor;
      listCursor += pg;
      for (logic [63:0] i = 0; i + 1 < epp; i++)
        mem[cur + 8 * i] = ({$urandom, $urandom} & ~(pg - 1)) | pg;
      mem[cur + 8 * (epp - 1)] = nxt;
      cur = nxt;
    end
  endtask

  task automatic runOne(logic [63:0] len, logic [63:0] pa, logic [63:0] pb, int pbits, bit poke);
    int cyc;
    bit ended;
    buildExpect(len, pa, pb, pbits);
    pending.delete();
    @(negedge clk);
    xferLen = LEN_W'(len); ptrA = pa; ptrB = pb; pageBits = PGB_W'(pbits);
    start = 1'b1;
    @(negedge clk);
    start = 1'b0;
    ended = 1'b0;
    for (cyc = 0; cyc < 6000; cyc++) begin
      if (doneFlag || errFlag) begin ended = 1'b1; break; end
      if (poke && cyc == 2) begin
        chk(busy == 1'b1, "R10", "busy during walk", 64'(busy), 64'h1);
        start = 1'b1; xferLen = 7; ptrA = 0; ptrB = 0;
      end else begin
        start = 1'b0;
      end
      segReady = ($urandom % 4) != 0;
      if (segValid && segReady) begin
        if (eSegAddr.size() == 0) begin
          chk(1'b0, eErr ? "R9" : "R2", "unexpected segment", segAddr, 64'h0);
        end else begin
          chk(segAddr == eSegAddr[0], eSegTag[0], "segAddr", segAddr, eSegAddr[0]);
          chk(64'(segLen) == eSegLen[0], eSegTag[0], "segLen", 64'(segLen), eSegLen[0]);
          void'(eSegAddr.pop_front()); void'(eSegLen.pop_front()); void'(eSegTag.pop_front());
        end
      end
      rdReqReady = ($urandom % 3) != 0;
      if (rdReqValid && rdReqReady) begin
        if (eReqAddr.size() == 0) begin
          chk(1'b0, "R4", "unexpected read request", rdReqAddr, 64'h0);
        end else begin
          chk(rdReqAddr == eReqAddr[0], eReqTag[0], "rdReqAddr", rdReqAddr, eReqAddr[0]);
          chk(64'(rdReqCount) == eReqCnt[0], eReqTag[0], "rdReqCount", 64'(rdReqCount), eReqCnt[0]);
          void'(eReqAddr.pop_front()); void'(eReqCnt.pop_front()); void'(eReqTag.pop_front());
        end
        for (logic [63:0] i = 0; i < 64'(rdReqCount); i++)
          pending.push_back(rdMem(rdReqAddr + 8 * i));
      end
      if (pending.size() > 0 && ($urandom % 4) != 0) begin
        rdRspValid = 1'b1;
        rdRspData = pending[0];
        if (rdRspReady) void'(pending.pop_front());
      end else begin
        rdRspValid = 1'b0;
      end
      @(negedge clk);
    end
    start = 1'b0; segReady = 1'b0; rdReqReady = 1'b0; rdRspValid = 1'b0;
    chk(ended, "R10", "walk ended", 64'(ended), 64'h1);
    if (eErr) begin
      chk(errFlag && !doneFlag, "R9", "error flag", {62'h0, errFlag, doneFlag}, 64'h2);
      chk(errCode == 8'h02 && noRetry, "R9", "errCode/noRetry", {55'h0, noRetry, errCode}, 64'h102);
      chk(pending.size() == 0, "R9", "owed beats drained", 64'(pending.size()), 64'h0);
    end else begin
      chk(doneFlag && !errFlag, "R2", "done flag", {62'h0, errFlag, doneFlag}, 64'h1);
      chk(errCode == 8'h00 && !noRetry, "R10", "clean status", {55'h0, noRetry, errCode}, 64'h0);
    end
    chk(eSegAddr.size() == 0, "R6", "segments missing", 64'(eSegAddr.size()), 64'h0);
    chk(eReqAddr.size() == 0, "R5", "requests missing", 64'(eReqAddr.size()), 64'h0);
    repeat (3) @(negedge clk);
    chk(doneFlag == !eErr && errFlag == eErr && !segValid, eErr ? "R9" : "R10",
        "flags held", {62'h0, errFlag, doneFlag}, {62'h0, eErr, !eErr});
  endtask

  task automatic freshMem();
    mem.delete();
    listCursor = LIST0 + 64'h0100_0000;
  endtask

  initial begin
    #(PERIOD * 200000);
    errors++;
    $display("FAIL watchdog expired");
    $display("  CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end

  initial begin
    void'($urandom(32'd1234));
    repeat (3) @(negedge clk);
    chk(!busy && !segValid && !rdReqValid && !rdRspReady && !doneFlag && !errFlag,
        "R10", "reset state", {58'h0, busy, segValid, rdReqValid, rdRspReady, doneFlag, errFlag}, 64'h0);
    rstN = 1'b1;
    @(negedge clk);

    // R1: zero first pointer
    freshMem(); runOne(100, 64'h0, LIST0, 5, 1'b0);
    // R2: transfer ends exactly at the first page end
    freshMem(); runOne(16, 64'h1010, LIST0, 5, 1'b0);
    // R3: bytes remain, second pointer zero
    freshMem(); runOne(100, 64'h1000, 64'h0, 5, 1'b0);
    // R4: direct aligned, then misaligned
    freshMem(); runOne(56, 64'h1008, 64'h4000, 5, 1'b0);
    freshMem(); runOne(56, 64'h1008, 64'h4004, 5, 1'b0);
    // R5: exactly one full list, last slot is data
    freshMem(); fillLists(LIST0, 5, 2); runOne(32 + 128, 64'h1000, LIST0, 5, 1'b0);
    // R7: one byte more forces a chain
    freshMem(); fillLists(LIST0, 5, 3); runOne(32 + 129, 64'h1000, LIST0, 5, 1'b0);
    // R7: zero chain pointer
    freshMem(); fillLists(LIST0, 5, 3); mem[LIST0 + 24] = 64'h0;
    runOne(32 + 200, 64'h1000, LIST0, 5, 1'b0);
    // R6: bad data entry mid-list with beats still owed
    freshMem(); fillLists(LIST0, 5, 3); mem[LIST0 + 8] = mem[LIST0 + 8] | 64'h4;
    runOne(32 + 128, 64'h1000, LIST0, 5, 1'b0);
    // R11: smallest page, long chain; large page
    freshMem(); fillLists(LIST0, 4, 12); runOne(16 * 9 + 3, 64'h2004, LIST0, 4, 1'b0);
    freshMem(); fillLists(LIST0, 10, 2); runOne(1024 * 5 + 77, 64'h3ff0, LIST0, 10, 1'b0);
    // R10: start while busy is ignored
    freshMem(); fillLists(LIST0, 5, 3); runOne(32 + 129, 64'h1000, LIST0, 5, 1'b1);

    for (int t = 0; t < 150; t++) begin
      int pbits, nl;
      logic [63:0] pg, len, pa, pb;
      freshMem();
      pbits = 4 + int'($urandom % 4);
      pg = 64'h1 << pbits;
      len = 1 + 64'($urandom % (32'(pg) * 24));
      pa = (($urandom % 20) == 0) ? 64'h0 : {$urandom, $urandom};
      case ($urandom % 10)
        0: pb = 64'h0;
        1: pb = LIST0 + 8 * 64'($urandom % 3 + 1);
        default: pb = LIST0;
      endcase
      nl = int'(len / pg) + 3;
      if (pb != 0) fillLists(pb, pbits, nl);
      if (($urandom % 8) == 0 && pb != 0) begin
        logic [63:0] k;
        k = pb + 8 * 64'($urandom % 6);
        mem[k] = (($urandom % 2) == 0) ? 64'h0 : (rdMem(k) | 64'h8);
      end
      runOne(len, pa, pb, pbits, 1'b0);
    end

    $display("  CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end

endmodule